// File: doc/BRIEF.md
# Seven-to-One Lane Deserializer with Failsafe

The block sits behind four serial data lanes and one forwarded-clock lane. All five are sampled by an outside bit clock that runs at seven times the word rate. Word boundaries come from the forwarded-clock lane. The bit sampled right after a low-to-high step on that lane is slot 0 of a frame. Each data lane carries seven slots per frame, and the four lanes together are rebuilt into one 28-bit word. Each word is presented with an output strobe whose rising edge marks the point where the word is valid.

Alignment has to be seen several frames in a row before any word is released. A clock lane that stops toggling is taken as a lost clock. In that case the last word is held and the strobe is parked high. Data lanes that float or idle high arrive as ones, so with the clock running they produce an all-ones word. An active-low power-down input clears the outputs and throws away the alignment.

Top module: `lane_deser7`

## Requirements
- R1: Word bit `lane*7 + s` holds the bit received on data lane `lane` in slot `s`. Slot 0 is the first bit sampled high on the clock lane after a sampled low.
- R2: Alignment locks on the 4th consecutive clock-lane rise in which each rise is 7 bit clocks after the one before. The first frame released is the frame of that 4th rise. Before that frame reaches the output, the strobe stays low.
- R3: A frame whose slot-0 bit is sampled at edge t appears on `word_out` after edge t+18. The strobe rise that marks it as valid comes after edge t+21.
- R4: While locked, the strobe is high for 4 bit clocks (slots 0 to 3) and low for 3 bit clocks (slots 4 to 6). `word_out` never changes while the strobe stays high.
- R5: When the clock lane runs and all data lanes are held high, the released word is all ones.
- R6: After TIMEOUT (default 21) consecutive bit clocks with no clock-lane transition, the strobe goes high and stays high, and `word_out` holds its value.
- R7: At the edge after `pwr_n` is sampled low, `word_out` is 0 and the strobe is low. Alignment restarts from nothing when `pwr_n` returns high.
- R8: While locked, a clock-lane rise that comes in any slot other than 0 drops the lock. The strobe then goes low and stays low until the next lock.
- R9: Out of reset, `word_out` is 0 and the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven cycles per frame |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_n | input | 1 | Power-down, active low |
| clk_lane | input | 1 | Sampled forwarded-clock lane |
| data_lanes | input | 4 | Sampled serial data lanes |
| word_out | output | 28 | Rebuilt parallel word |
| strobe_out | output | 1 | Output strobe; its rising edge marks a valid word |

## Verification
In the bench, frames are numbered from the first rise of a stream. Frame g is due on `word_out` after the slot-4 edge of frame g+2, and its strobe rise comes after the slot-0 edge of frame g+3. The bench compares against those two points only, sampling on the falling edge that follows each one. The lost-clock response needs TIMEOUT+1 quiet edges, so the bench samples it well past that count and checks that the word holds across a later window. Power-down is checked one bit clock after `pwr_n` falls. The misplaced-rise case is checked two bit clocks after the bad rise.

// File: rtl/lane_deser7.sv
module lane_deser7 #(
  parameter int LANES       = 4,
  parameter int SLOTS       = 7,
  parameter int LOCK_FRAMES = 4,
  parameter int TIMEOUT     = 21
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pwr_n,
  input  logic                   clk_lane,
  input  logic [LANES-1:0]       data_lanes,
  output logic [LANES*SLOTS-1:0] word_out,
  output logic                   strobe_out
);
  localparam int W  = LANES * SLOTS;
  localparam int SW = $clog2(SLOTS);
  localparam int HI = (SLOTS + 1) / 2;
  localparam int LW = $clog2(LOCK_FRAMES + 1);
  localparam int TW = $clog2(TIMEOUT + 1);

  logic             prev_c, locked, hv, h2v, ovalid;
  logic [SW-1:0]    sl;
  logic [LW-1:0]    mcnt;
  logic [TW-1:0]    idle;
  logic [SLOTS-1:0] sh [LANES];
  logic [W-1:0]     flat, hold, hold2;

  wire          clr       = !rst_n || !pwr_n;
  wire          rise      = clk_lane && !prev_c;
  wire          miss      = (idle == TW'(TIMEOUT));
  wire [SW-1:0] inc       = (sl == SW'(SLOTS - 1)) ? '0 : sl + SW'(1);
  wire [SW-1:0] nxt       = rise ? '0 : inc;
  wire          frame_end = (sl == SW'(SLOTS - 1));
  wire [LW-1:0] mcnt_inc  = mcnt + LW'(1);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (clr) sh[l] <= '0;
      else     sh[l] <= {data_lanes[l], sh[l][SLOTS-1:1]};
    end
    assign flat[l*SLOTS +: SLOTS] = sh[l];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      prev_c     <= 1'b0;
      sl         <= SW'(SLOTS - 1);
      locked     <= 1'b0;
      mcnt       <= '0;
      idle       <= '0;
      hold       <= '0;
      hold2      <= '0;
      hv         <= 1'b0;
      h2v        <= 1'b0;
      ovalid     <= 1'b0;
      word_out   <= '0;
      strobe_out <= 1'b0;
    end else begin
      prev_c <= clk_lane;
      sl     <= nxt;

      if (clk_lane != prev_c) idle <= '0;
      else if (!miss)         idle <= idle + TW'(1);

      if (miss) begin
        locked <= 1'b0;
        mcnt   <= '0;
      end else if (rise) begin
        if (inc == '0) begin
          if (!locked) begin
            mcnt <= mcnt_inc;
            if (mcnt_inc == LW'(LOCK_FRAMES)) locked <= 1'b1;
          end
        end else begin
          locked <= 1'b0;
          mcnt   <= LW'(1);
        end
      end

      if (!locked) begin
        hv     <= 1'b0;
        h2v    <= 1'b0;
        ovalid <= 1'b0;
      end else begin
        if (frame_end) begin
          hold  <= flat;
          hold2 <= hold;
          hv    <= 1'b1;
          h2v   <= hv;
        end
        if (sl == SW'(HI - 1) && !rise && h2v) begin
          word_out <= hold2;
          ovalid   <= 1'b1;
        end
      end

      strobe_out <= miss || (ovalid && locked && (nxt < SW'(HI)));
    end
  end
endmodule

// File: rtl/lane_deser7_chk.sv
module lane_deser7_chk #(
  parameter int W       = 28,
  parameter int TIMEOUT = 21
)(
  input logic         clk,
  input logic         rst_n,
  input logic         pwr_n,
  input logic         clk_lane,
  input logic [W-1:0] word_out,
  input logic         strobe_out
);
  int   quiet;
  logic pc;

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_n) begin
      quiet <= 0;
      pc    <= 1'b0;
    end else begin
      pc <= clk_lane;
      if (clk_lane != pc)        quiet <= 0;
      else if (quiet <= TIMEOUT) quiet <= quiet + 1;
    end
  end

  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (word_out == '0 && !strobe_out));

  assert_pd_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |=> (word_out == '0 && !strobe_out));

  assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_out && $past(strobe_out)) |-> $stable(word_out));

  assert_lost_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet > TIMEOUT) |-> strobe_out);
endmodule

bind lane_deser7 lane_deser7_chk #(.W(LANES*SLOTS), .TIMEOUT(TIMEOUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .clk_lane(clk_lane),
  .word_out(word_out), .strobe_out(strobe_out));

// File: tb/lane_deser7_tb_top.sv
`timescale 1ns/1ps
module lane_deser7_tb_top;
  localparam int N = 8;
  localparam logic [27:0] VEC [N] = '{
    28'h0000001, 28'h8000000, 28'hFFFFFFF, 28'hAAAAAAA,
    28'h5555555, 28'h1234567, 28'hFEDCBA9, 28'h0000000};

  logic        clk = 1'b0, rst_n = 1'b0, pwr_n = 1'b1, clk_lane = 1'b0;
  logic [3:0]  data_lanes = '0;
  logic [27:0] word_out;
  logic        strobe_out;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  lane_deser7 dut_i (.clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .clk_lane(clk_lane),
                     .data_lanes(data_lanes), .word_out(word_out), .strobe_out(strobe_out));

  task automatic chk(input bit ok, input string tag, input logic [27:0] act, input logic [27:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string word_tag(input logic [27:0] w);
    if (w == '1) return "R5";
    if ($countones(w) == 1) return "R1";
    return "R3";
  endfunction

  task automatic send_frame(input int g, input logic [27:0] w, input bit en);
    for (int s = 0; s < 7; s++) begin
      @(negedge clk);
      if (en && s == 1) begin
        if (g >= 6) begin
          chk(strobe_out == 1'b1, "R3 strobe rise", {27'd0, strobe_out}, 28'd1);
          chk(word_out == VEC[(g-3) % N], word_tag(VEC[(g-3) % N]), word_out, VEC[(g-3) % N]);
        end else
          chk(strobe_out == 1'b0, "R2 no strobe before lock", {27'd0, strobe_out}, 28'd0);
      end
      if (en && s == 4 && g >= 6)
        chk(strobe_out == 1'b1, "R4 strobe high slot3", {27'd0, strobe_out}, 28'd1);
      if (en && s == 5 && g >= 5) begin
        chk(word_out == VEC[(g-2) % N], word_tag(VEC[(g-2) % N]), word_out, VEC[(g-2) % N]);
        chk(strobe_out == 1'b0, "R4 strobe low slot4", {27'd0, strobe_out}, 28'd0);
      end
      clk_lane = (s < 4);
      for (int l = 0; l < 4; l++) data_lanes[l] = w[l*7 + s];
    end
  endtask

  task automatic run_stream(input int n);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      clk_lane = 1'b0;
      data_lanes = '0;
    end
    for (int g = 0; g < n; g++) send_frame(g, VEC[g % N], 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [27:0] rec;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(word_out == '0 && !strobe_out, "R9 reset state", word_out, 28'd0);

    run_stream(14);

    rec = '0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 30) begin
        rec = word_out;
        chk(strobe_out == 1'b1, "R6 strobe parked high", {27'd0, strobe_out}, 28'd1);
      end
      clk_lane = 1'b1;
      data_lanes = 4'h0;
    end
    @(negedge clk);
    chk(word_out == rec, "R6 word held", word_out, rec);
    chk(strobe_out == 1'b1, "R6 strobe still high", {27'd0, strobe_out}, 28'd1);

    run_stream(10);

    @(negedge clk);
    clk_lane = 1'b0;
    rec = word_out;
    for (int s = 0; s < 7; s++) begin
      @(negedge clk);
      if (s == 3) begin
        chk(strobe_out == 1'b0, "R8 lock dropped", {27'd0, strobe_out}, 28'd0);
        chk(word_out == rec, "R8 word unchanged", word_out, rec);
      end
      clk_lane = (s < 4);
      data_lanes = 4'hF;
    end

    run_stream(8);
    @(negedge clk);
    pwr_n = 1'b0;
    clk_lane = 1'b1;
    @(negedge clk);
    chk(word_out == '0 && !strobe_out, "R7 power-down clears", word_out, 28'd0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      clk_lane = (i % 7) < 4;
    end
    chk(word_out == '0 && !strobe_out, "R7 held low", word_out, 28'd0);
    pwr_n = 1'b1;
    run_stream(9);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule